// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a 16x16 multiplier with a 48-bit accumulator, driven through a plain register write port. Software first writes a control word that chooses the operand type, how many operand writes start an operation, squaring, the accumulate and subtract behaviour, and whether the accumulator is written at all. It then writes operand A and/or operand B. When the configured set of operand writes is complete, the block starts the operation by itself. The result lands on the rising edge that follows the triggering write.

The accumulator is held as three 16-bit words. Software can read or overwrite each word directly. A separate read-only 32-bit product register is always refreshed by an operation, even when accumulator writes are blocked. The overflow flag reflects the most recent operation.

The write port has no back-pressure: a write presented with `wr_en` high is taken on that rising edge, in every cycle, and reads are combinational from `rd_addr`. There is no stream interface. The operations complete in a fixed number of cycles and never stall.

Top module: `mac_unit`

## Requirements
- R1: After reset, every register reads 0 and `ovf_o` is 0. The address map is: 0 = control, 1 = operand A, 2 = operand B, 3..5 = accumulator words from low to high, 6..7 = product low and high, and unmapped addresses read 0. The control bits are: bit0 unsigned, bit1 single-operand, bit2 square, bit3 accumulate-enable, bit4 subtract, bit5 write-block. Bit6 is clear-data, which is write-only and reads 0.
- R2: With single-operand and square both 0, an operation starts only once both operand A and operand B have been written since the last start or control write. A write to only one of them leaves all results unchanged.
- R3: With single-operand 1 and square 0, every write to operand A or to operand B starts an operation using the current value of the other operand.
- R4: With square 1, a write to either operand address stores the value in both operand registers and starts an operation at once, whatever the single-operand bit holds.
- R5: A control write resets the pending-operand tracking, so operand writes made before it never count toward an operation. If the write has bit6 set, both operands become 0. If bit6 is clear, the operands are kept.
- R6: The operand write that completes a trigger is taken at clock edge k, and the accumulator, product and overflow flag change at edge k+1. Operand registers keep their values after an operation.
- R7: With unsigned 1, the operands are treated as 0..0xFFFF and the product is zero-extended. With unsigned 0, they are two's complement and the product is sign-extended to 48 bits.
- R8: With accumulate-enable 0, the accumulator receives the extended product, or its negation when subtract is 1. With accumulate-enable 1, the extended product is added to the accumulator, or subtracted from it when subtract is 1.
- R9: On unsigned accumulate, overflow is the carry out of bit 47; on unsigned subtract, it is the borrow. On signed accumulate or subtract, overflow is set exactly when the 48-bit two's-complement result overflows.
- R10: A plain store or a signed negate clears overflow. An unsigned negate sets overflow, and its accumulator and product values are undefined.
- R11: With write-block 1, an operation leaves all accumulator words unchanged but still updates the overflow flag. The product register, in every mode, receives the low 32 bits of the extended product, negated when subtract is 1.
- R12: A direct write to an accumulator word replaces that word. If it falls on the same edge as an operation result landing, the software value wins for that word and the other words take the result.
- R13: A control write that changes only the unsigned bit leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| acc_o | output | 48 | Accumulator, all words |
| prod_o | output | 32 | Product register |
| ovf_o | output | 1 | Overflow flag of the last operation |

## Verification
Two functions can meet on one edge: a result landing in the accumulator and a direct software write to an accumulator word. The bench provokes this by writing operand B to trigger an operation, then writing accumulator word 1 in the very next cycle. It then expects word 1 to hold the software value while words 0 and 2 carry the computed result. Back-to-back single-operand accumulates exercise a second overlap, in which a new trigger is taken on the same edge as the previous result lands; the bench judges this against a running arithmetic model of the accumulator.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic blk;
    logic sub;
    logic acc_en;
    logic square;
    logic single;
    logic uns;
  } mac_ctrl_t;

  localparam int CTRL_BITS = 6;
  localparam int CLR_BIT   = 6;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_OPA  = 1;
  localparam int ADDR_OPB  = 2;
  localparam int ADDR_ACC0 = 3;
endpackage

// File: rtl/mac_operand_ctrl.sv
module mac_operand_ctrl
  import mac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mac_ctrl_t         ctrl,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic              fire
);
  logic is_ctrl, is_a, is_b, trigger;
  logic a_seen, b_seen;

  always_comb begin
    is_ctrl = wr_en && (wr_addr == AW'(ADDR_CTRL));
    is_a    = wr_en && (wr_addr == AW'(ADDR_OPA));
    is_b    = wr_en && (wr_addr == AW'(ADDR_OPB));
    trigger = (is_a || is_b) &&
              (ctrl.square || ctrl.single || (is_a && b_seen) || (is_b && a_seen));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      op_a   <= '0;
      op_b   <= '0;
      a_seen <= 1'b0;
      b_seen <= 1'b0;
      fire   <= 1'b0;
    end else begin
      fire <= trigger;
      if (is_ctrl) begin
        ctrl   <= mac_ctrl_t'(wr_data[CTRL_BITS-1:0]);
        a_seen <= 1'b0;
        b_seen <= 1'b0;
        if (wr_data[CLR_BIT]) begin
          op_a <= '0;
          op_b <= '0;
        end
      end else if (is_a || is_b) begin
        if (ctrl.square) begin
          op_a <= wr_data;
          op_b <= wr_data;
        end else if (is_a) begin
          op_a <= wr_data;
        end else begin
          op_b <= wr_data;
        end
        if (trigger) begin
          a_seen <= 1'b0;
          b_seen <= 1'b0;
        end else if (is_a) begin
          a_seen <= 1'b1;
        end else begin
          b_seen <= 1'b1;
        end
      end
    end
  end

  p_ctrl_clears_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |=> (!a_seen && !b_seen));
  p_square_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl.square) |-> (op_a == op_b));
  p_pair_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_b && !a_seen && !ctrl.single && !ctrl.square) |=> !fire);
  p_single_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_a || is_b) && ctrl.single) |=> fire);
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int DATA_W    = 16,
  parameter int ACC_WORDS = 3,
  localparam int ACC_W  = DATA_W * ACC_WORDS,
  localparam int PROD_W = 2 * DATA_W,
  localparam int PF_W   = 2 * DATA_W + 2
) (
  input  logic              uns,
  input  logic              acc_en,
  input  logic              sub,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [ACC_W-1:0]  acc,
  output logic [ACC_W-1:0]  res,
  output logic [PROD_W-1:0] prod,
  output logic              ovf
);
  logic signed [DATA_W:0] a_x, b_x;
  logic signed [PF_W-1:0] p_full;
  logic [ACC_W-1:0] ext, opnd, store;
  logic [ACC_W:0]   sum;
  logic c_out, c_sign_in;

  always_comb begin
    a_x    = {(~uns) & op_a[DATA_W-1], op_a};
    b_x    = {(~uns) & op_b[DATA_W-1], op_b};
    p_full = a_x * b_x;
    ext    = {{(ACC_W-PF_W){p_full[PF_W-1]}}, p_full};
    store  = sub ? (~ext + ACC_W'(1)) : ext;
    opnd   = sub ? ~ext : ext;
    sum    = {1'b0, acc} + {1'b0, opnd} + {{ACC_W{1'b0}}, sub};
    c_out  = sum[ACC_W];
    c_sign_in = sum[ACC_W-1] ^ acc[ACC_W-1] ^ opnd[ACC_W-1];
    prod   = store[PROD_W-1:0];
    if (acc_en) begin
      res = sum[ACC_W-1:0];
      ovf = uns ? (c_out ^ sub) : (c_out ^ c_sign_in);
    end else begin
      res = store;
      ovf = uns & sub;
    end
  end
endmodule

// File: rtl/mac_state.sv
module mac_state
  import mac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_WORDS = 3,
  parameter int AW        = 3,
  localparam int ACC_W  = DATA_W * ACC_WORDS,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fire,
  input  mac_ctrl_t         ctrl,
  input  logic [ACC_W-1:0]  res,
  input  logic [PROD_W-1:0] prod_in,
  input  logic              ovf_in,
  output logic [ACC_W-1:0]  acc,
  output logic [PROD_W-1:0] prod,
  output logic              ovf
);
  logic [ACC_WORDS-1:0] hit;

  for (genvar i = 0; i < ACC_WORDS; i++) begin : g_word
    assign hit[i] = wr_en && (wr_addr == AW'(ADDR_ACC0 + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[i*DATA_W +: DATA_W] <= '0;
      end else if (hit[i]) begin
        acc[i*DATA_W +: DATA_W] <= wr_data;
      end else if (fire && !ctrl.blk) begin
        acc[i*DATA_W +: DATA_W] <= res[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0;
      ovf  <= 1'b0;
    end else if (fire) begin
      prod <= prod_in;
      ovf  <= ovf_in;
    end
  end

  p_block_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl.blk && (hit == '0)) |=> $stable(acc));
  p_prod_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (prod == $past(prod_in)));
  p_sw_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (acc[DATA_W-1:0] == $past(wr_data)));
  p_store_clears_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl.acc_en && !(ctrl.uns && ctrl.sub)) |=> !ovf);
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_WORDS = 3,
  localparam int ACC_W     = DATA_W * ACC_WORDS,
  localparam int PROD_W    = 2 * DATA_W,
  localparam int PROD_BASE = ADDR_ACC0 + ACC_WORDS,
  localparam int AW        = $clog2(PROD_BASE + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ACC_W-1:0]  acc_o,
  output logic [PROD_W-1:0] prod_o,
  output logic              ovf_o
);
  mac_ctrl_t         ctrl;
  logic [DATA_W-1:0] op_a, op_b;
  logic              fire;
  logic [ACC_W-1:0]  res;
  logic [PROD_W-1:0] prod_c;
  logic              ovf_c;

  mac_operand_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_ops (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .op_a(op_a), .op_b(op_b), .fire(fire)
  );

  mac_arith #(.DATA_W(DATA_W), .ACC_WORDS(ACC_WORDS)) u_arith (
    .uns(ctrl.uns), .acc_en(ctrl.acc_en), .sub(ctrl.sub),
    .op_a(op_a), .op_b(op_b), .acc(acc_o),
    .res(res), .prod(prod_c), .ovf(ovf_c)
  );

  mac_state #(.DATA_W(DATA_W), .ACC_WORDS(ACC_WORDS), .AW(AW)) u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fire(fire), .ctrl(ctrl), .res(res), .prod_in(prod_c), .ovf_in(ovf_c),
    .acc(acc_o), .prod(prod_o), .ovf(ovf_o)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_CTRL)) rd_data = DATA_W'(ctrl);
    if (rd_addr == AW'(ADDR_OPA))  rd_data = op_a;
    if (rd_addr == AW'(ADDR_OPB))  rd_data = op_b;
    for (int i = 0; i < ACC_WORDS; i++)
      if (rd_addr == AW'(ADDR_ACC0 + i)) rd_data = acc_o[i*DATA_W +: DATA_W];
    for (int j = 0; j < 2; j++)
      if (rd_addr == AW'(PROD_BASE + j)) rd_data = prod_o[j*DATA_W +: DATA_W];
  end
endmodule

// File: tb/tb_mac_unit.sv
`timescale 1ns/1ps
module tb_mac_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [47:0] acc_o;
  logic [31:0] prod_o;
  logic ovf_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  mac_unit dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .acc_o(acc_o), .prod_o(prod_o), .ovf_o(ovf_o));

  always #4 clk = ~clk;

  logic [47:0] e_acc;
  logic [31:0] e_prod;
  logic e_of;
  logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
  logic [47:0] inits [4] = '{48'h0, 48'h7FFF_FFFF_FFFF, 48'h8000_0000_0000, 48'hFFFF_FFFF_FFFF};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic load_acc(input logic [47:0] v);
    wr(3'd3, v[15:0]); wr(3'd4, v[31:16]); wr(3'd5, v[47:32]);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // arithmetic model of one operation
  task automatic model(input bit uns, input bit acc_en, input bit sub, input bit blk,
                       input logic [15:0] a, input logic [15:0] b);
    longint pa, pb, p;
    logic [47:0] ext, st;
    logic [48:0] r;
    pa = uns ? longint'(a) : longint'($signed(a));
    pb = uns ? longint'(b) : longint'($signed(b));
    p = pa * pb;
    ext = p[47:0];
    st = sub ? (48'd0 - ext) : ext;
    e_prod = st[31:0];
    if (acc_en) begin
      r = sub ? ({1'b0, e_acc} - {1'b0, ext}) : ({1'b0, e_acc} + {1'b0, ext});
      if (uns) e_of = r[48];
      else if (sub) e_of = (e_acc[47] != ext[47]) && (r[47] != e_acc[47]);
      else e_of = (e_acc[47] == ext[47]) && (r[47] != e_acc[47]);
      if (!blk) e_acc = r[47:0];
    end else begin
      e_of = uns & sub;
      if (!blk) e_acc = st;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state and readback
    chk("R1 acc", acc_o, 0); chk("R1 prod", prod_o, 0); chk("R1 ovf", ovf_o, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd7, d); chk("R1 prod hi", d, 0);
    wr(3'd0, 16'h007F);
    rd(3'd0, d); chk("R1 ctrl readback hides clear bit", d, 16'h003F);

    // R2 pair mode: A alone does nothing
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd3); settle(); settle();
    chk("R2 no fire after A only", acc_o, 0);
    wr(3'd2, 16'd5); settle();
    chk("R2 fire after B acc", acc_o, 48'd15);
    chk("R6 result one edge after trigger prod", prod_o, 32'd15);
    rd(3'd1, d); chk("R6 operand A kept", d, 16'd3);

    // R5 ctrl write resets counter, keeps operands
    wr(3'd1, 16'd7);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd2); settle(); settle();
    chk("R5 pending A discarded", acc_o, 48'd15);
    rd(3'd1, d); chk("R5 operand A kept", d, 16'd7);
    wr(3'd1, 16'd4); settle();
    chk("R5 fresh pair fires", acc_o, 48'd8);
    // R5 clear-data bit
    wr(3'd0, 16'h0040);
    rd(3'd1, d); chk("R5 clear A", d, 0);
    rd(3'd2, d); chk("R5 clear B", d, 0);

    // R3 single operand accumulate chain, back-to-back triggers
    wr(3'd0, 16'h0000); wr(3'd1, 16'd6); wr(3'd2, 16'd10); settle();
    wr(3'd0, 16'h000A);
    e_acc = 48'd60;
    wr(3'd1, 16'd3); model(0, 1, 0, 0, 16'd3, 16'd10);
    wr(3'd2, 16'hFFFF); model(0, 1, 0, 0, 16'd3, 16'hFFFF);
    wr(3'd1, 16'd100); model(0, 1, 0, 0, 16'd100, 16'hFFFF);
    settle();
    chk("R3 single-operand accumulate chain", acc_o, e_acc);

    // R4 square mode ignores single bit
    wr(3'd0, 16'h0004); load_acc(0);
    wr(3'd2, 16'hFFFD); settle();
    rd(3'd1, d); chk("R4 mirror into A", d, 16'hFFFD);
    chk("R4 signed square", acc_o, 48'd9);
    wr(3'd0, 16'h0007);
    wr(3'd1, 16'hFFFF); settle();
    chk("R4 unsigned square", acc_o, 48'hFFFE_0001);

    // R12 software write coincides with landing result
    wr(3'd0, 16'h0000); load_acc(48'h1111_2222_3333);
    wr(3'd1, 16'hFFFD); wr(3'd2, 16'd5); wr(3'd4, 16'hABCD); settle();
    chk("R12 sw word wins, others take result", acc_o, 48'hFFFF_ABCD_FFF1);

    // R13 signedness change keeps acc
    wr(3'd0, 16'h0001);
    chk("R13 acc unchanged by type switch", acc_o, 48'hFFFF_ABCD_FFF1);

    // Sweep R7 R8 R9 R10 R11
    for (int m = 0; m < 16; m++)
      for (int ai = 0; ai < 6; ai++)
        for (int bi = 0; bi < 6; bi++)
          for (int ki = 0; ki < 4; ki++) begin
            bit uns, ae, sb, bk;
            uns = m[0]; ae = m[1]; sb = m[2]; bk = m[3];
            wr(3'd0, {10'd0, bk, sb, ae, 1'b0, 1'b0, uns});
            load_acc(inits[ki]);
            e_acc = inits[ki];
            wr(3'd1, vals[ai]); wr(3'd2, vals[bi]); settle();
            model(uns, ae, sb, bk, vals[ai], vals[bi]);
            if (ae) chk("R9 overflow on accumulate", ovf_o, e_of);
            else chk("R10 overflow on store/negate", ovf_o, e_of);
            if (!(uns && sb && !ae)) begin
              if (bk) chk("R11 acc held under block", acc_o, e_acc);
              else if (ae) chk("R8 accumulate result", acc_o, e_acc);
              else chk("R7 extended store", acc_o, e_acc);
              chk("R11 product register", prod_o, e_prod);
            end
          end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule